// File: doc/BRIEF.md
# Clock Fan-out Configuration Target with Indexed Block Access

This block is the two-wire configuration target of a four-output differential clock buffer. It answers one fixed 7-bit bus address. It keeps a small bank of 8-bit control registers, which the host reaches through indexed block transfers. A write carries a starting offset, then a nonzero byte count, then that many payload bytes. A read first sets the offset with a short write. It then uses a repeated start with the read bit. The target replies with the number of registers left from that offset, followed by the register contents, until the host answers with NACK.

The register bits are combined with pin-level controls to decide which differential pairs are driven. These controls are two per-pair enable pins (for the first and the last pair), a stop pin and a power-down pin. A polarity-select pin flips the sense of all four. While power-down is asserted, the target ignores the bus and keeps the data line released, but it keeps its register contents. The open-drain data line appears as a separate input and a pull-low output.

Top module: `clkbuf_smbus_cfg`

## Requirements
- R1: Only address 7'b1101110 (0x6E) is acknowledged, with bit 0 of the first byte selecting write (0) or read (1). Any other address is NACKed, and SDA stays released until the next start.
- R2: A write frame (address, offset, count, then N payload bytes) has every byte ACKed. The payload is stored from the offset upward, with the index auto-incremented after each byte.
- R3: A count byte of 0x00 is NACKed and nothing is stored. Payload bytes beyond the announced count are NACKed and not stored.
- R4: After a read address, the target first sends a count byte equal to NUM_REGS minus the index, or 0 when the index is at or past NUM_REGS. It then sends registers from the index upward and releases SDA after the host's NACK.
- R5: Writes to register 1 (read-only identifier ID_VAL, default 0x5A) or past the last register are ACKed but ignored. Reads past the last register return 0x00.
- R6: Reset values are: register 0 = 0x0F (bit i enables pair i), register 1 = ID_VAL, registers 2 and 3 = 0x00. bw_override_o follows register 2 bit 0.
- R7: out_en_o[i] is 1 only when register 0 bit i is 1, stop and power-down are inactive, and, for pair 0 and pair NUM_OUT-1, the matching oe_pin_i bit (bit 0 and bit 1 respectively) is active.
- R8: With oe_inv_i = 0, the enable pins are active high and the stop and power-down pins are active low. With oe_inv_i = 1, all four are inverted.
- R9: While power-down is active, every byte is NACKed and register contents are kept.
- R10: A stop (SDA rising while SCL is high) returns the target to idle. A start (SDA falling while SCL is high) restarts the address phase. The register index is kept across transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_drive_low_o | output | 1 | 1 pulls the data line low |
| oe_pin_i | input | 2 | Enable pins for pair 0 (bit 0) and pair NUM_OUT-1 (bit 1) |
| stop_pin_i | input | 1 | Stop control pin, polarity set by oe_inv_i |
| pwrdn_pin_i | input | 1 | Power-down control pin, polarity set by oe_inv_i |
| oe_inv_i | input | 1 | Polarity select for the enable, stop and power-down pins |
| out_en_o | output | NUM_OUT | 1 drives the pair, 0 tristates it |
| bw_override_o | output | 1 | Loop-bandwidth override bit from register 2 |

## Verification
The bench builds the block with its defaults: NUM_OUT = 4, NUM_REGS = 4, SLV_ADDR = 0x6E and ID_VAL = 0x5A. With only four registers, a three-byte burst from offset 3 runs past the end. This exercises both the ignored writes and the 0x00 fill on reads, along with the count byte that drops to 1 or 0. A table walks the pin combinations of both polarities against the gated enables. Directed bus transfers then cover zero counts, surplus bytes, foreign addresses, power-down and index retention.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_TXACK
  } bus_state_e;

  typedef enum logic [2:0] {
    PH_ADDR, PH_OFS, PH_CNT, PH_WDATA, PH_RD
  } rx_phase_e;
endpackage

// File: rtl/cbs_bus_sync.sv
module cbs_bus_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] scl_q, sda_q;
  logic       scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 2'b11;
      sda_q <= 2'b11;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_i};
      sda_q <= {sda_q[0], sda_i};
      scl_d <= scl_q[1];
      sda_d <= sda_q[1];
    end
  end

  assign sda_s_o    = sda_q[1];
  assign scl_rise_o = scl_q[1] & ~scl_d;
  assign scl_fall_o = ~scl_q[1] & scl_d;
  assign start_o    = scl_q[1] & scl_d & sda_d & ~sda_q[1];
  assign stop_o     = scl_q[1] & scl_d & ~sda_d & sda_q[1];
endmodule

// File: rtl/cbs_regfile.sv
module cbs_regfile #(
  parameter int          NUM_REGS = 4,
  parameter int          NUM_OUT  = 4,
  parameter logic [7:0]  ID_VAL   = 8'h5A
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [7:0]         wr_idx_i,
  input  logic [7:0]         wr_data_i,
  input  logic [7:0]         rd_idx_i,
  output logic [7:0]         rd_data_o,
  output logic [NUM_OUT-1:0] en_bits_o,
  output logic               bw_o
);
  localparam int         IW   = $clog2(NUM_REGS);
  localparam logic [7:0] RST0 = 8'((1 << NUM_OUT) - 1);
  localparam logic [7:0] NREG = 8'(NUM_REGS);

  logic [NUM_REGS-1:0][7:0] reg_q;
  logic                     wr_ok;

  assign wr_ok = wr_en_i && (wr_idx_i < NREG) && (wr_idx_i != 8'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++)
        reg_q[i] <= (i == 0) ? RST0 : (i == 1) ? ID_VAL : 8'h00;
    end else if (wr_ok) begin
      reg_q[wr_idx_i[IW-1:0]] <= wr_data_i;
    end
  end

  assign rd_data_o = (rd_idx_i < NREG) ? reg_q[rd_idx_i[IW-1:0]] : 8'h00;
  assign en_bits_o = reg_q[0][NUM_OUT-1:0];
  assign bw_o      = reg_q[2][0];

  // R5: ignored writes leave the bank untouched
  a_r5_ignored_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_idx_i >= NREG || wr_idx_i == 8'd1)) |=> $stable(reg_q));
endmodule

// File: rtl/cbs_out_ctrl.sv
module cbs_out_ctrl #(
  parameter int NUM_OUT = 4
) (
  input  logic [NUM_OUT-1:0] en_bits_i,
  input  logic [1:0]         oe_pin_i,
  input  logic               stop_pin_i,
  input  logic               pwrdn_pin_i,
  input  logic               oe_inv_i,
  output logic               halt_o,
  output logic               pd_o,
  output logic [NUM_OUT-1:0] out_en_o
);
  logic [1:0] pin_en;
  logic       stop_act;

  assign pin_en   = oe_inv_i ? ~oe_pin_i : oe_pin_i;
  assign stop_act = oe_inv_i ? stop_pin_i : ~stop_pin_i;
  assign pd_o     = oe_inv_i ? pwrdn_pin_i : ~pwrdn_pin_i;
  assign halt_o   = stop_act | pd_o;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_pair
    if (i == 0) begin : g_first
      assign out_en_o[i] = en_bits_i[i] & pin_en[0] & ~halt_o;
    end else if (i == NUM_OUT - 1) begin : g_last
      assign out_en_o[i] = en_bits_i[i] & pin_en[1] & ~halt_o;
    end else begin : g_mid
      assign out_en_o[i] = en_bits_i[i] & ~halt_o;
    end
  end
endmodule

// File: rtl/cbs_smb_engine.sv
module cbs_smb_engine
  import cbs_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h6E,
  parameter int         NUM_REGS = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hold_i,
  input  logic       sda_s_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [7:0] rd_data_i,
  output logic [7:0] rd_idx_o,
  output logic       wr_en_o,
  output logic [7:0] wr_idx_o,
  output logic [7:0] wr_data_o,
  output logic       sda_low_o
);
  localparam logic [7:0] NREG = 8'(NUM_REGS);

  bus_state_e state_q;
  rx_phase_e  phase_q;
  logic [3:0] cnt_q;
  logic [7:0] sh_q, idx_q, remain_q, rd_cnt;
  logic       ack_q, go_tx_q;

  assign rd_cnt   = (idx_q < NREG) ? NREG - idx_q : 8'h00;
  assign rd_idx_o = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_ADDR;
      cnt_q     <= '0;
      sh_q      <= '0;
      idx_q     <= '0;
      remain_q  <= '0;
      ack_q     <= 1'b0;
      go_tx_q   <= 1'b0;
      sda_low_o <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (hold_i || stop_i) begin
        state_q   <= ST_IDLE;
        sda_low_o <= 1'b0;
      end else if (start_i) begin
        state_q   <= ST_RX;
        phase_q   <= PH_ADDR;
        cnt_q     <= '0;
        go_tx_q   <= 1'b0;
        sda_low_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RX: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[6:0], sda_s_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              state_q <= ST_ACK;
              cnt_q   <= '0;
              ack_q   <= 1'b0;
              unique case (phase_q)
                PH_ADDR: if (sh_q[7:1] == SLV_ADDR) begin
                  ack_q     <= 1'b1;
                  sda_low_o <= 1'b1;
                  go_tx_q   <= sh_q[0];
                  phase_q   <= sh_q[0] ? PH_RD : PH_OFS;
                end
                PH_OFS: begin
                  ack_q     <= 1'b1;
                  sda_low_o <= 1'b1;
                  idx_q     <= sh_q;
                  phase_q   <= PH_CNT;
                end
                PH_CNT: if (sh_q != 8'h00) begin
                  ack_q     <= 1'b1;
                  sda_low_o <= 1'b1;
                  remain_q  <= sh_q;
                  phase_q   <= PH_WDATA;
                end
                PH_WDATA: if (remain_q != 8'h00) begin
                  ack_q     <= 1'b1;
                  sda_low_o <= 1'b1;
                  wr_en_o   <= 1'b1;
                  wr_idx_o  <= idx_q;
                  wr_data_o <= sh_q;
                  idx_q     <= idx_q + 8'd1;
                  remain_q  <= remain_q - 8'd1;
                end
                default: ;
              endcase
            end
          end
          ST_ACK: if (scl_fall_i) begin
            sda_low_o <= 1'b0;
            cnt_q     <= '0;
            if (!ack_q) begin
              state_q <= ST_IDLE;
            end else if (go_tx_q) begin
              state_q   <= ST_TX;
              sh_q      <= rd_cnt;
              sda_low_o <= ~rd_cnt[7];
              go_tx_q   <= 1'b0;
            end else begin
              state_q <= ST_RX;
            end
          end
          ST_TX: if (scl_fall_i) begin
            if (cnt_q == 4'd7) begin
              sda_low_o <= 1'b0;
              state_q   <= ST_TXACK;
            end else begin
              cnt_q     <= cnt_q + 4'd1;
              sh_q      <= {sh_q[6:0], 1'b0};
              sda_low_o <= ~sh_q[6];
            end
          end
          ST_TXACK: begin
            if (scl_rise_i) begin
              ack_q <= ~sda_s_i;
            end else if (scl_fall_i) begin
              cnt_q <= '0;
              if (ack_q) begin
                state_q   <= ST_TX;
                sh_q      <= rd_data_i;
                sda_low_o <= ~rd_data_i[7];
                idx_q     <= idx_q + 8'd1;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9: power-down releases the line
  a_r9_pd_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !sda_low_o);
  // R1: the line is pulled only in acknowledge or transmit slots
  a_r1_drive_slots: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_low_o |-> (state_q == ST_ACK || state_q == ST_TX));
  // R3: a store needs a nonzero remaining count
  a_r3_store_in_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(remain_q) != 8'h00);
  // R10: stop returns to idle with the line released
  a_r10_stop_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (state_q == ST_IDLE && !sda_low_o));
endmodule

// File: rtl/clkbuf_smbus_cfg.sv
module clkbuf_smbus_cfg #(
  parameter int         NUM_OUT  = 4,
  parameter int         NUM_REGS = 4,
  parameter logic [6:0] SLV_ADDR = 7'h6E,
  parameter logic [7:0] ID_VAL   = 8'h5A
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_drive_low_o,
  input  logic [1:0]         oe_pin_i,
  input  logic               stop_pin_i,
  input  logic               pwrdn_pin_i,
  input  logic               oe_inv_i,
  output logic [NUM_OUT-1:0] out_en_o,
  output logic               bw_override_o
);
  logic               sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic               pd_act, halt;
  logic               wr_en;
  logic [7:0]         wr_idx, wr_data, rd_idx, rd_data;
  logic [NUM_OUT-1:0] en_bits;

  cbs_bus_sync u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_s_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  cbs_smb_engine #(.SLV_ADDR(SLV_ADDR), .NUM_REGS(NUM_REGS)) u_engine (
    .clk_i, .rst_ni, .hold_i(pd_act), .sda_s_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .rd_data_i(rd_data), .rd_idx_o(rd_idx),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .sda_low_o(sda_drive_low_o)
  );

  cbs_regfile #(.NUM_REGS(NUM_REGS), .NUM_OUT(NUM_OUT), .ID_VAL(ID_VAL)) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data), .en_bits_o(en_bits),
    .bw_o(bw_override_o)
  );

  cbs_out_ctrl #(.NUM_OUT(NUM_OUT)) u_out (
    .en_bits_i(en_bits), .oe_pin_i, .stop_pin_i, .pwrdn_pin_i, .oe_inv_i,
    .halt_o(halt), .pd_o(pd_act), .out_en_o
  );

  // R7: stop or power-down tristates every pair
  a_r7_halt_all_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt |-> (out_en_o == '0));
endmodule

// File: tb/clkbuf_smbus_cfg_bench.sv
module clkbuf_smbus_cfg_bench;
  localparam int Q = 8;
  localparam logic [6:0] ADDR = 7'h6E;
  localparam logic [7:0] ID = 8'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_low;
  logic [1:0] oe_pin = 2'b11;
  logic stop_pin = 1'b1, pwrdn_pin = 1'b1, oe_inv = 1'b0;
  logic [3:0] out_en;
  logic bw;
  logic sda_wire;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  assign sda_wire = m_sda & ~sda_low;

  clkbuf_smbus_cfg u_clkbuf_smbus_cfg (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_wire),
    .sda_drive_low_o(sda_low), .oe_pin_i(oe_pin), .stop_pin_i(stop_pin),
    .pwrdn_pin_i(pwrdn_pin), .oe_inv_i(oe_inv), .out_en_o(out_en),
    .bw_override_o(bw)
  );

  // {inv, stop, pwrdn, oe0, oe3, expected out_en} with register 0 = 0x0F
  localparam logic [8:0] VEC [12] = '{
    {5'b0_1_1_1_1, 4'hF}, {5'b0_1_1_0_1, 4'hE}, {5'b0_1_1_1_0, 4'h7},
    {5'b0_0_1_1_1, 4'h0}, {5'b0_1_0_1_1, 4'h0}, {5'b0_1_1_0_0, 4'h6},
    {5'b1_0_0_0_0, 4'hF}, {5'b1_0_0_1_0, 4'hE}, {5'b1_0_0_0_1, 4'h7},
    {5'b1_1_0_0_0, 4'h0}, {5'b1_0_1_0_0, 4'h0}, {5'b1_1_1_1_1, 4'h0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
    end
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); ack = ~sda_wire; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); m_scl = 1'b1; wq(); b[i] = sda_wire; wq(); m_scl = 1'b0;
    end
    m_sda = ~give_ack; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq(); m_sda = 1'b1;
  endtask

  // acks: [0] address, [1] offset, [2] count, [3+k] payload byte k
  task automatic do_write(input logic [6:0] addr, input logic [7:0] ofs,
                          input logic [7:0] cnt, input int nsend,
                          input logic [31:0] dat, output logic [6:0] acks);
    logic a;
    acks = '0;
    bus_start();
    send_byte({addr, 1'b0}, a); acks[0] = a;
    send_byte(ofs, a); acks[1] = a;
    send_byte(cnt, a); acks[2] = a;
    for (int k = 0; k < nsend; k++) begin
      send_byte(dat[8*k +: 8], a); acks[3+k] = a;
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] ofs, input int nrecv,
                         output logic [7:0] cnt_b, output logic [31:0] dat);
    logic a;
    logic [7:0] b;
    dat = '0;
    bus_start();
    send_byte({ADDR, 1'b0}, a);
    send_byte(ofs, a);
    bus_start();
    send_byte({ADDR, 1'b1}, a);
    recv_byte(nrecv > 0, cnt_b);
    for (int k = 0; k < nrecv; k++) begin
      recv_byte(k < nrecv - 1, b); dat[8*k +: 8] = b;
    end
    bus_stop();
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [6:0] acks;
    logic [7:0] cb;
    logic [31:0] rd;
    logic a;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6 reset state
    chk(out_en == 4'hF, "R6 reset out_en", out_en, 4'hF);
    chk(bw == 1'b0, "R6 reset bw_override", bw, 0);
    chk(sda_low == 1'b0, "R6 reset sda released", sda_low, 0);

    // R7 R8 pin table
    for (int i = 0; i < 12; i++) begin
      {oe_inv, stop_pin, pwrdn_pin, oe_pin[0], oe_pin[1]} = VEC[i][8:4];
      #1;
      chk(out_en == VEC[i][3:0], $sformatf("R7/R8 vector %0d", i), out_en, VEC[i][3:0]);
      @(negedge clk);
    end
    oe_inv = 1'b0; stop_pin = 1'b1; pwrdn_pin = 1'b1; oe_pin = 2'b11;
    wq();

    // R4 R6 full read from offset 0
    do_read(8'd0, 4, cb, rd);
    chk(cb == 8'd4, "R4 count from offset 0", cb, 4);
    chk(rd == {8'h00, 8'h00, ID, 8'h0F}, "R6 reset register values", rd, {8'h00, 8'h00, ID, 8'h0F});
    chk(sda_low == 1'b0, "R4 line released after NACK", sda_low, 0);

    // R2 burst write offset 2
    do_write(ADDR, 8'd2, 8'd2, 2, 32'h0000_7701, acks);
    chk(acks[4:0] == 5'h1F, "R2 write acks", acks, 7'h1F);
    chk(bw == 1'b1, "R6 bw_override follows reg2 bit0", bw, 1);
    do_read(8'd2, 2, cb, rd);
    chk(cb == 8'd2, "R4 count from offset 2", cb, 2);
    chk(rd[15:0] == 16'h7701, "R2 readback offset 2", rd[15:0], 16'h7701);

    // R7 register gating
    do_write(ADDR, 8'd0, 8'd1, 1, 32'h05, acks);
    chk(out_en == 4'h5, "R7 register enables", out_en, 4'h5);
    do_write(ADDR, 8'd0, 8'd1, 1, 32'h0F, acks);
    chk(out_en == 4'hF, "R7 register enables restored", out_en, 4'hF);

    // R5 read-only identifier
    do_write(ADDR, 8'd1, 8'd1, 1, 32'h33, acks);
    chk(acks[3] == 1'b1, "R5 write to reg1 acked", acks[3], 1);
    do_read(8'd1, 1, cb, rd);
    chk(rd[7:0] == ID, "R5 reg1 unchanged", rd[7:0], ID);

    // R5 past-end write and read
    do_write(ADDR, 8'd3, 8'd3, 3, 32'h00EF_CDAB, acks);
    chk(acks[5:0] == 6'h3F, "R5 past-end writes acked", acks, 7'h3F);
    do_read(8'd3, 2, cb, rd);
    chk(cb == 8'd1, "R4 count from offset 3", cb, 1);
    chk(rd[15:0] == 16'h00AB, "R5 past-end read zero", rd[15:0], 16'h00AB);
    do_read(8'd5, 1, cb, rd);
    chk(cb == 8'd0 && rd[7:0] == 8'h00, "R4 count beyond end", {cb, rd[7:0]}, 0);

    // R3 zero count and surplus bytes
    do_write(ADDR, 8'd3, 8'd0, 0, 32'h0, acks);
    chk(acks[2:0] == 3'b011, "R3 zero count NACK", acks[2:0], 3'b011);
    do_write(ADDR, 8'd3, 8'd1, 2, 32'h0000_2211, acks);
    chk(acks[4:3] == 2'b01, "R3 surplus byte NACK", acks[4:3], 2'b01);
    do_read(8'd3, 1, cb, rd);
    chk(rd[7:0] == 8'h11, "R3 only counted byte stored", rd[7:0], 8'h11);

    // R1 foreign addresses
    do_write(7'h50, 8'd0, 8'd1, 1, 32'h00, acks);
    chk(acks == 7'h00, "R1 foreign address silent", acks, 0);
    do_write(7'h6F, 8'd0, 8'd1, 1, 32'h00, acks);
    chk(acks == 7'h00, "R1 neighbour address silent", acks, 0);
    chk(out_en == 4'hF, "R1 reg0 unchanged", out_en, 4'hF);

    // R9 power-down
    pwrdn_pin = 1'b0;
    wq();
    do_write(ADDR, 8'd3, 8'd1, 1, 32'h99, acks);
    chk(acks == 7'h00, "R9 bus ignored in power-down", acks, 0);
    chk(out_en == 4'h0, "R9 outputs off in power-down", out_en, 0);
    pwrdn_pin = 1'b1;
    wq();
    do_read(8'd3, 1, cb, rd);
    chk(rd[7:0] == 8'h11, "R9 registers kept", rd[7:0], 8'h11);

    // R10 stop mid-frame, index kept across transactions
    bus_start();
    send_byte({ADDR, 1'b0}, a);
    send_byte(8'd2, a);
    bus_stop();
    chk(sda_low == 1'b0, "R10 idle after stop", sda_low, 0);
    bus_start();
    send_byte({ADDR, 1'b1}, a);
    chk(a == 1'b1, "R10 read address acked", a, 1);
    recv_byte(1'b1, cb);
    recv_byte(1'b0, rd[7:0]);
    bus_stop();
    chk(cb == 8'd2 && rd[7:0] == 8'h01, "R10 index retained", {cb, rd[7:0]}, 16'h0201);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule